// File: doc/BRIEF.md
# Word-Mode SPI Master Channel

This block is one SPI master channel. Outgoing items enter a transmit FIFO through a valid/ready stream. A serial engine shifts each item out most significant bit first, and each returned item is stored in a receive FIFO, which is drained through a second valid/ready stream. An item is a 32-bit word in word mode or a single byte in byte mode. Both FIFOs hold 16 items, and their fill levels are reported in bytes.

Software-style control inputs are plain level signals. They set:
- clock polarity;
- the serial clock divider;
- the transmit and receive channel enables;
- a soft reset that flushes both FIFOs;
- receive byte and halfword swapping;
- a packet limit on how many received items are kept.

Chip select is never driven by the engine. It simply follows a software inactive bit. Streams use the usual rule: a transfer happens on a clock edge where valid and ready are both high. The producer must hold valid and data steady until that edge. The consumer may hold ready low for as long as it likes.

Top module: `spiw_master`

## Requirements
- R1: `status` carries the receive FIFO level in bits 21:15, the transmit FIFO level in bits 12:6 and transmit-done in bit 0; all other bits read 0. Levels count bytes: 4 per stored item in word mode (`cfg_word`=1), 1 per item in byte mode. Each FIFO holds 16 items.
- R2: `spi_sclk` idles at `cfg_cpol`; with `cfg_cpol`=0 the clock is active high and idles low. Each half period of the serial clock lasts `cfg_clk_div`+1 cycles of `clk`.
- R3: Data leaves MSB first. `spi_mosi` changes only on the trailing clock edge and never on the leading edge. `spi_miso` is sampled on the leading edge (mode 0 when `cfg_cpol`=0).
- R4: While `cfg_tx_en` is 0, `tx_ready` is 0, no item is accepted and no transfer starts.
- R5: While `cfg_rx_en` is 0, transfers still shift, but returned items are discarded and the receive level does not grow.
- R6: A cycle with `cfg_soft_rst` high empties both FIFOs, aborts any transfer in flight and clears the packet tally.
- R7: With `cfg_pkt_en`=1, only the first `cfg_pkt_words` items returned since reset or the last soft reset are stored. Later transfers still run, but their returned data is dropped.
- R8: In word mode with `cfg_swap_en`=1, `cfg_swap_byte` exchanges the two bytes inside each halfword and `cfg_swap_half` exchanges the halfwords. Setting both reverses the byte order. Swapping has no effect in byte mode.
- R9: Byte mode sends `tx_data[7:0]` as an 8-bit frame and returns the received byte zero-extended on `rx_data`.
- R10: Transmit-done (status bit 0) is 1 exactly when the transmit FIFO is empty and no frame is shifting.
- R11: `tx_ready` is 0 while the transmit FIFO is full. `rx_valid` is 1 while the receive FIFO holds data, and a pop happens when `rx_ready` is also 1. A frame whose data would be stored does not start while the receive FIFO is full.
- R12: `spi_cs_n` equals `cfg_cs_inact` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_word | input | 1 | 1 = 32-bit items, 0 = byte items |
| cfg_tx_en | input | 1 | Transmit channel enable |
| cfg_rx_en | input | 1 | Receive channel enable |
| cfg_soft_rst | input | 1 | Flush FIFOs and abort the engine |
| cfg_swap_en | input | 1 | Receive swap enable |
| cfg_swap_byte | input | 1 | Swap bytes within halfwords |
| cfg_swap_half | input | 1 | Swap halfwords |
| cfg_pkt_en | input | 1 | Packet limit enable |
| cfg_pkt_words | input | 16 | Number of items to keep |
| cfg_clk_div | input | 8 | Half period minus one, in core cycles |
| cfg_cs_inact | input | 1 | Chip select inactive (high) |
| tx_valid | input | 1 | Transmit item offered |
| tx_ready | output | 1 | Transmit item accepted |
| tx_data | input | 32 | Transmit item |
| rx_valid | output | 1 | Receive item available |
| rx_ready | input | 1 | Receive item taken |
| rx_data | output | 32 | Receive item |
| status | output | 32 | Levels and transmit-done |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench ties `spi_miso` back to `spi_mosi`, directly or inverted. It sweeps every swap combination against both polarities and several divider ratios, and rebuilds each frame bit by bit from the pins.

A design with a wrong bit order, the wrong sampling edge or an off-by-one divider would return a mangled word or show an uneven clock. A swap module with crossed controls would return the wrong byte order.

The packet limit is exercised at its exact boundary, where an off-by-one tally keeps one item too many or too few. The receive FIFO is driven completely full, and so is the transmit FIFO behind it. A design that ignored the full receive FIFO would overwrite data or report a level above 64. A soft reset that missed one FIFO would leave a nonzero level in the status word.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
  localparam int unsigned LVL_W      = 7;
  localparam int unsigned RXLVL_LSB  = 15;
  localparam int unsigned TXLVL_LSB  = 6;
  localparam int unsigned TXDONE_BIT = 0;

  // Receive swap: byte exchange inside each halfword, then halfword exchange.
  function automatic logic [31:0] rx_swap(input logic [31:0] w,
                                          input logic bsw,
                                          input logic hsw);
    logic [31:0] t;
    t = bsw ? {w[23:16], w[31:24], w[7:0], w[15:8]} : w;
    return hsw ? {t[15:0], t[31:16]} : t;
  endfunction
endpackage

// File: rtl/spiw_fifo.sv
module spiw_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spiw_shifter.sv
module spiw_shifter #(
  parameter int unsigned W     = 32,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned BC_W = $clog2(W),
  localparam int unsigned BYTE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             word_mode,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  input  logic [W-1:0]     load,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word,
  output logic             sclk,
  output logic             mosi
);
  logic [DIV_W-1:0] div_cnt;
  logic             half;      // 0: waiting for leading edge, 1: trailing
  logic [BC_W-1:0]  bit_cnt;
  logic [W-1:0]     sh_out, sh_in;
  logic             sclk_q;
  logic             tick;

  assign tick    = (div_cnt == div);
  assign done    = busy && tick && half && (bit_cnt == '0);
  assign sclk    = busy ? sclk_q : cpol;
  assign mosi    = sh_out[W-1];
  assign rx_word = word_mode ? sh_in : {{(W-BYTE){1'b0}}, sh_in[BYTE-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      half    <= 1'b0;
      bit_cnt <= '0;
      sh_out  <= '0;
      sh_in   <= '0;
      sclk_q  <= 1'b0;
    end else if (abort) begin
      busy    <= 1'b0;
      half    <= 1'b0;
      div_cnt <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      div_cnt <= '0;
      half    <= 1'b0;
      bit_cnt <= word_mode ? BC_W'(W - 1) : BC_W'(BYTE - 1);
      sh_out  <= word_mode ? load : {load[BYTE-1:0], {(W-BYTE){1'b0}}};
      sh_in   <= '0;
      sclk_q  <= cpol;
    end else if (busy) begin
      if (tick) begin
        div_cnt <= '0;
        if (!half) begin
          sclk_q <= ~cpol;
          sh_in  <= {sh_in[W-2:0], miso};
          half   <= 1'b1;
        end else begin
          sclk_q <= cpol;
          half   <= 1'b0;
          if (bit_cnt == '0) begin
            busy <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt - 1'b1;
            sh_out  <= {sh_out[W-2:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiw_rx_swap.sv
module spiw_rx_swap (
  input  logic        word_mode,
  input  logic        swap_en,
  input  logic        swap_byte,
  input  logic        swap_half,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  import spiw_pkg::*;
  always_comb begin
    if (word_mode && swap_en) dout = rx_swap(din, swap_byte, swap_half);
    else                      dout = din;
  end
endmodule

// File: rtl/spiw_master.sv
module spiw_master #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PKT_W = 16,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cpol,
  input  logic             cfg_word,
  input  logic             cfg_tx_en,
  input  logic             cfg_rx_en,
  input  logic             cfg_soft_rst,
  input  logic             cfg_swap_en,
  input  logic             cfg_swap_byte,
  input  logic             cfg_swap_half,
  input  logic             cfg_pkt_en,
  input  logic [PKT_W-1:0] cfg_pkt_words,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic             cfg_cs_inact,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [31:0]      tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [31:0]      rx_data,
  output logic [31:0]      status,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  import spiw_pkg::*;

  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0]   tx_head, sh_rx, rx_swapped;
  logic          sh_busy, sh_done, start, store_ok, rx_push, tx_push, rx_pop;
  logic [PKT_W-1:0] pkt_seen;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;

  assign store_ok = cfg_rx_en && (!cfg_pkt_en || (pkt_seen < cfg_pkt_words));
  assign tx_ready = cfg_tx_en && !tx_full && !cfg_soft_rst;
  assign tx_push  = tx_valid && tx_ready;
  assign start    = !sh_busy && cfg_tx_en && !tx_empty && !cfg_soft_rst &&
                    !(store_ok && rx_full);
  assign rx_push  = sh_done && store_ok && !cfg_soft_rst;
  assign rx_valid = !rx_empty;
  assign rx_pop   = rx_valid && rx_ready;
  assign spi_cs_n = cfg_cs_inact;

  spiw_fifo #(.W(32), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(cfg_soft_rst),
    .push(tx_push), .din(tx_data), .pop(start), .dout(tx_head),
    .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  spiw_shifter #(.W(32), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(cfg_soft_rst), .start(start),
    .word_mode(cfg_word), .cpol(cfg_cpol), .div(cfg_clk_div),
    .load(tx_head), .miso(spi_miso), .busy(sh_busy), .done(sh_done),
    .rx_word(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  spiw_rx_swap u_swap (
    .word_mode(cfg_word), .swap_en(cfg_swap_en), .swap_byte(cfg_swap_byte),
    .swap_half(cfg_swap_half), .din(sh_rx), .dout(rx_swapped)
  );

  spiw_fifo #(.W(32), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(cfg_soft_rst),
    .push(rx_push), .din(rx_swapped), .pop(rx_pop), .dout(rx_data),
    .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  // Tally of stored items, compared against the packet limit.
  always_ff @(posedge clk) begin
    if (!rst_n || cfg_soft_rst)            pkt_seen <= '0;
    else if (rx_push && (pkt_seen != '1))  pkt_seen <= pkt_seen + 1'b1;
  end

  // Levels in bytes: four per word item, one per byte item.
  assign tx_lvl = cfg_word ? (LVL_W'(tx_cnt) << 2) : LVL_W'(tx_cnt);
  assign rx_lvl = cfg_word ? (LVL_W'(rx_cnt) << 2) : LVL_W'(rx_cnt);

  always_comb begin
    status = '0;
    status[RXLVL_LSB +: LVL_W] = rx_lvl;
    status[TXLVL_LSB +: LVL_W] = tx_lvl;
    status[TXDONE_BIT]         = tx_empty && !sh_busy;
  end
endmodule

// File: rtl/spiw_master_chk.sv
module spiw_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_cpol,
  input logic        cfg_tx_en,
  input logic        cfg_rx_en,
  input logic        cfg_soft_rst,
  input logic        tx_ready,
  input logic [31:0] status,
  input logic        spi_sclk,
  input logic        spi_mosi
);
  logic [6:0] rxl, txl;
  assign rxl = status[21:15];
  assign txl = status[12:6];

  // R1: neither level can exceed 16 words of 4 bytes
  p_lvl_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rxl <= 7'd64) && (txl <= 7'd64));

  // R2: idle serial clock sits at the polarity level
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (spi_sclk == cfg_cpol));

  // R3: data out holds still across a leading edge
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((spi_sclk != cfg_cpol) && ($past(spi_sclk) == cfg_cpol) &&
     ($past(cfg_cpol) == cfg_cpol)) |-> $stable(spi_mosi));

  // R4: no acceptance while transmit channel is off
  p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |-> !tx_ready);

  // R5: receive level does not grow while receive channel is off
  p_rx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_rx_en) |-> (rxl <= $past(rxl)));

  // R6: soft reset leaves both FIFOs empty
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_soft_rst) |-> ((rxl == 7'd0) && (txl == 7'd0)));
endmodule

bind spiw_master spiw_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_tx_en(cfg_tx_en),
  .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst), .tx_ready(tx_ready),
  .status(status), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spiw_master_tb_top.sv
module spiw_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 0, cfg_word = 1, cfg_tx_en = 1, cfg_rx_en = 1;
  logic cfg_soft_rst = 0, cfg_swap_en = 0, cfg_swap_byte = 0, cfg_swap_half = 0;
  logic cfg_pkt_en = 0, cfg_cs_inact = 1;
  logic [15:0] cfg_pkt_words = 16'd0;
  logic [7:0]  cfg_clk_div = 8'd0;
  logic tx_valid = 0, rx_ready = 0, miso_inv = 0;
  logic [31:0] tx_data = '0;
  logic tx_ready, rx_valid, spi_sclk, spi_mosi, spi_miso, spi_cs_n;
  logic [31:0] rx_data, status;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign spi_miso = spi_mosi ^ miso_inv;

  spiw_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_word(cfg_word),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst),
    .cfg_swap_en(cfg_swap_en), .cfg_swap_byte(cfg_swap_byte),
    .cfg_swap_half(cfg_swap_half), .cfg_pkt_en(cfg_pkt_en),
    .cfg_pkt_words(cfg_pkt_words), .cfg_clk_div(cfg_clk_div),
    .cfg_cs_inact(cfg_cs_inact), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .status(status), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // Pin monitor: rebuild frames on leading edges, time the half periods.
  logic [31:0] mon_sh = '0;
  logic        prev_sclk = 1'b0, prev_cpol = 1'b0, gap_err = 1'b0;
  int          gap = 0;
  always @(posedge clk) begin
    if (rst_n && (spi_sclk != prev_sclk) && (prev_cpol == cfg_cpol)) begin
      if (spi_sclk != cfg_cpol) mon_sh <= {mon_sh[30:0], spi_mosi};
      else if (gap != int'(cfg_clk_div) + 1) gap_err <= 1'b1;
      gap <= 1;
    end else begin
      gap <= gap + 1;
    end
    prev_sclk <= spi_sclk;
    prev_cpol <= cfg_cpol;
  end

  function automatic logic [31:0] exp_swap(input logic [31:0] w,
                                           input logic en, input logic b,
                                           input logic h);
    logic [31:0] r;
    r = w;
    if (en && b) r = {r[23:16], r[31:24], r[7:0], r[15:8]};
    if (en && h) r = {r[15:0], r[31:16]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (!status[0] && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic pop(input logic [31:0] exp, input string req);
    @(negedge clk);
    chk(rx_valid === 1'b1, req, {31'd0, rx_valid}, 32'd1);
    chk(rx_data === exp, req, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic soft_reset();
    @(negedge clk);
    cfg_soft_rst = 1'b1;
    @(negedge clk);
    cfg_soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic [31:0] words [16];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R10: reset state shows empty levels and transmit done
    chk(status === 32'h1, "R1 R10 reset status", status, 32'h1);
    chk(spi_cs_n === 1'b1, "R12 cs inactive", {31'd0, spi_cs_n}, 32'd1);
    chk(spi_sclk === 1'b0, "R2 idle low", {31'd0, spi_sclk}, 32'd0);
    chk(rx_valid === 1'b0, "R11 rx empty", {31'd0, rx_valid}, 32'd0);
    cfg_cs_inact = 1'b0;
    @(negedge clk);
    chk(spi_cs_n === 1'b0, "R12 cs active", {31'd0, spi_cs_n}, 32'd0);

    // R2 R3 R8: sweep polarity, divider and every swap setting
    for (int cp = 0; cp < 2; cp++) begin
      for (int dv = 0; dv < 3; dv++) begin
        for (int sw = 0; sw < 8; sw++) begin
          cfg_cpol = cp[0];
          cfg_clk_div = 8'(dv);
          {cfg_swap_en, cfg_swap_byte, cfg_swap_half} = 3'(sw);
          @(negedge clk);
          chk(spi_sclk === cfg_cpol, "R2 idle level", {31'd0, spi_sclk},
              {31'd0, cfg_cpol});
          gap_err = 1'b0;
          w = {8'(sw * 37 + dv), 8'(cp * 91 + 5), 8'h3C ^ 8'(sw), 8'hC1 ^ 8'(dv)};
          push(w);
          wait_idle();
          chk(mon_sh === w, "R3 msb-first frame", mon_sh, w);
          chk(gap_err === 1'b0, "R2 half period", {31'd0, gap_err}, 32'd0);
          chk(status[21:15] === 7'd4, "R1 rx level word", {25'd0, status[21:15]}, 32'd4);
          pop(exp_swap(w, cfg_swap_en, cfg_swap_byte, cfg_swap_half), "R8 swap");
        end
      end
    end
    cfg_cpol = 1'b0;
    cfg_clk_div = 8'd0;
    {cfg_swap_en, cfg_swap_byte, cfg_swap_half} = 3'b000;

    // R3: inverted loopback proves sampling of the input pin
    miso_inv = 1'b1;
    push(32'h1234_F00D);
    wait_idle();
    pop(~32'h1234_F00D, "R3 miso sampled");
    miso_inv = 1'b0;

    // R9 R8: byte mode, swap requested but ignored
    cfg_word = 1'b0;
    {cfg_swap_en, cfg_swap_byte, cfg_swap_half} = 3'b111;
    push(32'hDEAD_BE5A);
    push(32'h0000_01A7);
    push(32'hFFFF_FF80);
    wait_idle();
    chk(status[21:15] === 7'd3, "R1 R9 byte level", {25'd0, status[21:15]}, 32'd3);
    chk(mon_sh[7:0] === 8'h80, "R9 byte frame", {24'd0, mon_sh[7:0]}, 32'h80);
    pop(32'h5A, "R9 R8 byte rx");
    pop(32'hA7, "R9 byte rx");
    pop(32'h80, "R9 byte rx");
    cfg_word = 1'b1;
    {cfg_swap_en, cfg_swap_byte, cfg_swap_half} = 3'b000;

    // R7: keep exactly three of five
    cfg_pkt_en = 1'b1;
    cfg_pkt_words = 16'd3;
    soft_reset();
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + 32'(i));
    wait_idle();
    chk(status[21:15] === 7'd12, "R7 packet limit", {25'd0, status[21:15]}, 32'd12);
    chk(mon_sh === 32'hA000_0004, "R7 later frames shift", mon_sh, 32'hA000_0004);
    for (int i = 0; i < 3; i++) pop(32'hA000_0000 + 32'(i), "R7 kept item");
    @(negedge clk);
    chk(rx_valid === 1'b0, "R7 nothing extra", {31'd0, rx_valid}, 32'd0);
    cfg_pkt_en = 1'b0;

    // R5: receive off drops data but frames still shift
    cfg_rx_en = 1'b0;
    push(32'h5555_AAAA);
    push(32'h0F0F_7777);
    wait_idle();
    chk(status[21:15] === 7'd0, "R5 rx off level", {25'd0, status[21:15]}, 32'd0);
    chk(mon_sh === 32'h0F0F_7777, "R5 still shifts", mon_sh, 32'h0F0F_7777);
    cfg_rx_en = 1'b1;

    // R4: transmit off refuses items
    cfg_tx_en = 1'b0;
    @(negedge clk);
    chk(tx_ready === 1'b0, "R4 ready low", {31'd0, tx_ready}, 32'd0);
    tx_valid = 1'b1;
    tx_data = 32'hBAD0_BAD0;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    chk(status === 32'h1, "R4 nothing queued", status, 32'h1);
    cfg_tx_en = 1'b1;

    // R11 R1 R10: fill receive FIFO, then transmit FIFO behind it
    for (int i = 0; i < 16; i++) begin
      words[i] = 32'h3000_0000 ^ (32'(i) * 32'h0101_0101);
      push(words[i]);
    end
    wait_idle();
    chk(status[21:15] === 7'd64, "R1 R11 rx full", {25'd0, status[21:15]}, 32'd64);
    for (int i = 0; i < 16; i++) push(32'h7700_0000 + 32'(i));
    repeat (4) @(negedge clk);
    chk(tx_ready === 1'b0, "R11 tx full ready", {31'd0, tx_ready}, 32'd0);
    chk(status[12:6] === 7'd64, "R11 stalled by rx full", {25'd0, status[12:6]}, 32'd64);
    chk(status[0] === 1'b0, "R10 not done", {31'd0, status[0]}, 32'd0);
    pop(words[0], "R11 first out");
    repeat (200) @(negedge clk);
    chk(status[12:6] === 7'd60, "R11 one frame resumed", {25'd0, status[12:6]}, 32'd60);
    chk(status[21:15] === 7'd64, "R11 rx full again", {25'd0, status[21:15]}, 32'd64);

    // R6: soft reset flushes both
    soft_reset();
    chk(status === 32'h1, "R6 flushed", status, 32'h1);
    chk(rx_valid === 1'b0, "R6 rx empty", {31'd0, rx_valid}, 32'd0);
    chk(spi_sclk === 1'b0, "R6 clock idle", {31'd0, spi_sclk}, 32'd0);

    finish_run();
  end
endmodule